// File: doc/BRIEF.md
# Bus-Master IDE DMA Channel Control Registers

This block holds the host-visible control and status state of one bus-mastering IDE DMA channel. Software reaches three registers through a plain single-cycle register port: a command byte, a status byte and a 32-bit pointer to the descriptor table in memory. The block turns command writes into one-cycle start and stop requests for a separate descriptor-walking transfer engine. It holds the transfer direction and the table address steady for that engine while a transfer runs.

Events come back from the engine and the drive: completion, stop acknowledge, error and the device interrupt. The block folds them into the status byte. The status byte mixes three kinds of bit. A live busy bit follows the engine. Sticky event bits are cleared by writing one. Software-owned flags record which drives have been configured. One read-only bit reports, from a parameter, whether the two channels of a controller must take turns. The port is plain control and status: a write is accepted on every cycle where `reg_wr` is high, reads are combinational from `reg_sel`, and there is no back-pressure.

Register selector: 0 is command, 1 is status, 2 is the table pointer, 3 is unused. The byte registers read zero-extended to 32 bits.

Top module: `bmdma_regs`

## Requirements
- R1: After reset, command and pointer read 0, `eng_start`, `eng_stop` and `eng_dir_in` are 0, and status reads only the simplex bit (0x80 with the default parameter).
- R2: Writing the command with bit 0 set, while the run bit is 0 and the engine is idle, sets status bit 0 and gives a single-cycle `eng_start` pulse in the cycle after the write. `eng_start` and `eng_stop` are never high together.
- R3: Command bit 3 is the direction: 1 means device-to-memory, 0 means memory-to-device. 0x09 starts an input transfer and 0x01 starts an output transfer. `eng_dir_in` follows the stored bit. The command reads back only bits 0 and 3.
- R4: A change to bit 3 that is written while the run bit is 1 is ignored.
- R5: Writing bit 0 as 0 while the engine is active gives a one-cycle `eng_stop` pulse in the cycle after the write. Status bit 0 stays 1 until `eng_stop_ack` is sampled and reads 0 in the cycle after that.
- R6: `eng_done` clears status bit 0 in the next cycle, and the run bit keeps its value. Writing bit 0 as 1 again while the run bit is 1 gives no new start.
- R7: `eng_err` sets status bit 1 and ends activity. Only a write of 1 to bit 1 clears it. If the error and the clearing write fall in the same cycle, the bit stays set.
- R8: Status bit 2 is set by `dev_irq` once the engine is idle. A request that arrives during a transfer is held and sets the bit in the cycle after the engine finishes. Writing 1 to bit 2 clears it.
- R9: Status bits 5 and 6 are read/write storage. Bits 3 and 4 read 0. Bit 7 equals the SIMPLEX parameter, and writes to it are ignored.
- R10: The pointer register stores all 32 written bits, reads them back, and drives `eng_tbl_addr`.
- R11: A command write made while a stop is pending (run bit 0, engine still active) is ignored in full.
- R12: Selector 3 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selector |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| eng_start | output | 1 | One-cycle start request to the engine |
| eng_stop | output | 1 | One-cycle abort request to the engine |
| eng_dir_in | output | 1 | 1 = device-to-memory transfer |
| eng_tbl_addr | output | 32 | Descriptor table address |
| eng_done | input | 1 | Engine finished the table |
| eng_stop_ack | input | 1 | Engine has halted after an abort |
| eng_err | input | 1 | Engine reports a transfer error |
| dev_irq | input | 1 | Drive interrupt request |

## Verification
The command path is driven with input and output starts, repeated starts, direction flips during a run, and a restart attempt while a stop is still pending. These patterns separate edge-triggered starting from level-triggered starting and show whether direction is locked. The status path is driven with a drive interrupt while idle and one in the middle of a transfer, which shows whether the flush condition is honoured. Errors are applied with and without a clearing write in the same cycle, which shows the set-wins priority. A full-ones write to the status byte separates the sticky, stored, read-only and reserved bits in one read.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CMD  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_PTR  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // command byte fields
  localparam int CMD_RUN = 0;
  localparam int CMD_DIR = 3;

  // status byte fields
  localparam int ST_ACT = 0;
  localparam int ST_ERR = 1;
  localparam int ST_INT = 2;
  localparam int ST_CFG = 5;   // first software-owned drive flag
  localparam int CFG_N  = 2;   // number of drive flags
  localparam int ST_SPX = 7;

  typedef struct packed {
    logic       spx;
    logic [1:0] cfg;
    logic [1:0] rsvd;
    logic       intr;
    logic       err;
    logic       act;
  } stat_t;
endpackage

// File: rtl/bmdma_cmd.sv
module bmdma_cmd
  import bmdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              active,
  output logic              run_q,
  output logic              dir_q,
  output logic              start_acc,
  output logic              start_p,
  output logic              stop_p
);
  logic wr_ok;
  logic stop_req;

  // a write during a pending stop is dropped whole
  always_comb begin
    wr_ok     = wr_cmd && !(!run_q && active);
    start_acc = wr_ok && !run_q && wdata[CMD_RUN];
    stop_req  = wr_ok && run_q && !wdata[CMD_RUN];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      dir_q   <= 1'b0;
      start_p <= 1'b0;
      stop_p  <= 1'b0;
    end else begin
      start_p <= start_acc;
      stop_p  <= stop_req && active;
      if (start_acc)
        run_q <= 1'b1;
      else if (stop_req)
        run_q <= 1'b0;
      if (wr_ok && !run_q)
        dir_q <= wdata[CMD_DIR];
    end
  end
endmodule

// File: rtl/bmdma_status.sv
module bmdma_status
  import bmdma_pkg::*;
#(
  parameter bit SIMPLEX = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_acc,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic              eng_stop_ack,
  input  logic              dev_irq,
  input  logic              wr_stat,
  input  logic [BYTE_W-1:0] wdata,
  output stat_t             stat,
  output logic              active
);
  logic             act_q, err_q, int_q, irq_hold_q;
  logic [CFG_N-1:0] cfg_q;
  logic             finish, flushed, irq_req;
  logic             clr_err, clr_int;

  always_comb begin
    finish  = eng_done || eng_err || eng_stop_ack;
    flushed = !act_q || finish;
    irq_req = dev_irq || irq_hold_q;
    clr_err = wr_stat && wdata[ST_ERR];
    clr_int = wr_stat && wdata[ST_INT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q      <= 1'b0;
      err_q      <= 1'b0;
      int_q      <= 1'b0;
      irq_hold_q <= 1'b0;
    end else begin
      if (start_acc)
        act_q <= 1'b1;
      else if (act_q && finish)
        act_q <= 1'b0;
      err_q      <= eng_err || (err_q && !clr_err);
      int_q      <= (irq_req && flushed) || (int_q && !clr_int);
      irq_hold_q <= irq_req && !flushed;
    end
  end

  // drive-configured flags, one flop each
  for (genvar i = 0; i < CFG_N; i++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n)
        cfg_q[i] <= 1'b0;
      else if (wr_stat)
        cfg_q[i] <= wdata[ST_CFG+i];
    end
  end

  always_comb begin
    stat.spx  = SIMPLEX;
    stat.cfg  = cfg_q;
    stat.rsvd = '0;
    stat.intr = int_q;
    stat.err  = err_q;
    stat.act  = act_q;
  end

  assign active = act_q;
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter bit SIMPLEX = 1'b1,
  parameter int PTR_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              eng_start,
  output logic              eng_stop,
  output logic              eng_dir_in,
  output logic [PTR_W-1:0]  eng_tbl_addr,
  input  logic              eng_done,
  input  logic              eng_stop_ack,
  input  logic              eng_err,
  input  logic              dev_irq
);
  reg_sel_e         sel;
  logic             wr_cmd, wr_stat, wr_ptr;
  logic             run_w, dir_w, start_acc, act_w;
  stat_t            stat_w;
  logic [PTR_W-1:0] ptr_q;

  always_comb begin
    sel     = reg_sel_e'(reg_sel);
    wr_cmd  = reg_wr && (sel == SEL_CMD);
    wr_stat = reg_wr && (sel == SEL_STAT);
    wr_ptr  = reg_wr && (sel == SEL_PTR);
  end

  bmdma_cmd u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_cmd    (wr_cmd),
    .wdata     (reg_wdata[BYTE_W-1:0]),
    .active    (act_w),
    .run_q     (run_w),
    .dir_q     (dir_w),
    .start_acc (start_acc),
    .start_p   (eng_start),
    .stop_p    (eng_stop)
  );

  bmdma_status #(.SIMPLEX(SIMPLEX)) u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_acc    (start_acc),
    .eng_done     (eng_done),
    .eng_err      (eng_err),
    .eng_stop_ack (eng_stop_ack),
    .dev_irq      (dev_irq),
    .wr_stat      (wr_stat),
    .wdata        (reg_wdata[BYTE_W-1:0]),
    .stat         (stat_w),
    .active       (act_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (wr_ptr)
      ptr_q <= reg_wdata[PTR_W-1:0];
  end

  assign eng_dir_in   = dir_w;
  assign eng_tbl_addr = ptr_q;

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_CMD: begin
        reg_rdata[CMD_RUN] = run_w;
        reg_rdata[CMD_DIR] = dir_w;
      end
      SEL_STAT: reg_rdata[BYTE_W-1:0] = stat_w;
      SEL_PTR:  reg_rdata[PTR_W-1:0]  = ptr_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bmdma_chk.sv
module bmdma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [1:0]  reg_sel,
  input logic [31:0] reg_wdata,
  input logic        eng_start,
  input logic        eng_stop,
  input logic        eng_dir_in,
  input logic        eng_done,
  input logic        eng_stop_ack,
  input logic        eng_err,
  input logic        run,
  input logic        act,
  input logic        err
);
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start); // R2
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_start, eng_stop})); // R2
  AST_ACT_ROSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act) |-> eng_start); // R2
  AST_DIR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(eng_dir_in)); // R4
  AST_STOP_WHEN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_stop |-> $past(act)); // R5
  AST_ACT_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act) |-> $past(eng_done || eng_err || eng_stop_ack)); // R5
  AST_ERR_ROSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(eng_err)); // R7
  AST_ERR_FELL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $past(reg_wr && reg_sel == 2'd1 && reg_wdata[1] && !eng_err)); // R7
endmodule

bind bmdma_regs bmdma_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_sel      (reg_sel),
  .reg_wdata    (reg_wdata),
  .eng_start    (eng_start),
  .eng_stop     (eng_stop),
  .eng_dir_in   (eng_dir_in),
  .eng_done     (eng_done),
  .eng_stop_ack (eng_stop_ack),
  .eng_err      (eng_err),
  .run          (run_w),
  .act          (act_w),
  .err          (stat_w.err)
);

// File: tb/sim_bmdma_regs.sv
`timescale 1ns/1ps
module sim_bmdma_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eng_start, eng_stop, eng_dir_in;
  logic [31:0] eng_tbl_addr;
  logic        eng_done = 1'b0, eng_stop_ack = 1'b0, eng_err = 1'b0, dev_irq = 1'b0;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bmdma_regs u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
    .eng_stop(eng_stop), .eng_dir_in(eng_dir_in), .eng_tbl_addr(eng_tbl_addr),
    .eng_done(eng_done), .eng_stop_ack(eng_stop_ack), .eng_err(eng_err),
    .dev_irq(dev_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_run, m_dir, m_act, m_err, m_int, m_hold, m_pstart, m_pstop;
  bit [1:0] m_cfg;
  bit [31:0] m_ptr;

  function automatic logic [31:0] model_read(input logic [1:0] s);
    case (s)
      2'd0: return {28'd0, m_dir, 2'b00, m_run};
      2'd1: return {24'd0, 1'b1, m_cfg, 2'b00, m_int, m_err, m_act};
      2'd2: return m_ptr;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_dir = 0; m_act = 0; m_err = 0; m_int = 0; m_hold = 0;
      m_pstart = 0; m_pstop = 0; m_cfg = 0; m_ptr = 0;
    end else begin
      bit wc, ws, wp, ok, sacc, sreq, fin, fl, req, n_int;
      wc = reg_wr && reg_sel == 2'd0;
      ws = reg_wr && reg_sel == 2'd1;
      wp = reg_wr && reg_sel == 2'd2;
      ok = wc && !(!m_run && m_act);
      sacc = ok && !m_run && reg_wdata[0];
      sreq = ok && m_run && !reg_wdata[0];
      fin = eng_done || eng_err || eng_stop_ack;
      fl = !m_act || fin;
      req = dev_irq || m_hold;
      n_int = (req && fl) || (m_int && !(ws && reg_wdata[2]));
      m_pstart = sacc;
      m_pstop = sreq && m_act;
      if (ok && !m_run) m_dir = reg_wdata[3];
      if (sacc) m_run = 1; else if (sreq) m_run = 0;
      m_err = eng_err || (m_err && !(ws && reg_wdata[1]));
      m_int = n_int;
      m_hold = req && !fl;
      if (sacc) m_act = 1; else if (m_act && fin) m_act = 0;
      if (ws) m_cfg = reg_wdata[6:5];
      if (wp) m_ptr = reg_wdata;
    end
    #3;
    if (rst_n && !finished) begin
      chk("R2 eng_start vs model", {31'd0, eng_start}, {31'd0, m_pstart});
      chk("R5 eng_stop vs model", {31'd0, eng_stop}, {31'd0, m_pstop});
      chk("R3 eng_dir_in vs model", {31'd0, eng_dir_in}, {31'd0, m_dir});
      chk("R10 eng_tbl_addr vs model", eng_tbl_addr, m_ptr);
      chk(reg_sel == 2'd1 ? "R7 status read vs model" :
          reg_sel == 2'd0 ? "R3 command read vs model" :
          reg_sel == 2'd2 ? "R10 pointer read vs model" : "R12 unused read vs model",
          reg_rdata, model_read(reg_sel));
    end
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    reg_sel = s;
    #1;
    v = reg_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
  endtask
  task automatic pulse_ack();
    @(negedge clk); eng_stop_ack = 1'b1; @(negedge clk); eng_stop_ack = 1'b0;
  endtask
  task automatic pulse_err();
    @(negedge clk); eng_err = 1'b1; @(negedge clk); eng_err = 1'b0;
  endtask
  task automatic pulse_irq();
    @(negedge clk); dev_irq = 1'b1; @(negedge clk); dev_irq = 1'b0;
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    rd(2'd0, v); chk("R1 command after reset", v, 32'h0);
    rd(2'd1, v); chk("R1 status after reset", v, 32'h80);
    rd(2'd2, v); chk("R1 pointer after reset", v, 32'h0);
    chk("R1 engine outputs after reset", {29'd0, eng_start, eng_stop, eng_dir_in}, 32'h0);

    // R10 pointer
    wr(2'd2, 32'h1234_5678);
    rd(2'd2, v); chk("R10 pointer readback", v, 32'h1234_5678);
    chk("R10 pointer drives engine", eng_tbl_addr, 32'h1234_5678);

    // R2 R3 input start
    wr(2'd0, 32'h09);
    chk("R2 start pulse after 0x09", {31'd0, eng_start}, 32'h1);
    chk("R3 direction input", {31'd0, eng_dir_in}, 32'h1);
    rd(2'd0, v); chk("R3 command readback 0x09", v, 32'h09);
    rd(2'd1, v); chk("R2 active bit set", v, 32'h81);
    @(negedge clk);
    chk("R2 start pulse lasts one cycle", {31'd0, eng_start}, 32'h0);

    // R4 R6 direction locked, no restart
    wr(2'd0, 32'h01);
    chk("R6 no second start pulse", {31'd0, eng_start}, 32'h0);
    chk("R4 direction held while running", {31'd0, eng_dir_in}, 32'h1);
    rd(2'd0, v); chk("R4 command keeps direction", v, 32'h09);
    pulse_done();
    rd(2'd1, v); chk("R6 done clears active", v, 32'h80);
    rd(2'd0, v); chk("R6 run bit kept after done", v, 32'h09);
    wr(2'd0, 32'h00);
    chk("R5 no stop pulse when idle", {31'd0, eng_stop}, 32'h0);

    // R3 output start, R5 abort, R11 pending stop
    wr(2'd0, 32'h01);
    chk("R3 direction output", {31'd0, eng_dir_in}, 32'h0);
    chk("R2 start pulse after 0x01", {31'd0, eng_start}, 32'h1);
    wr(2'd0, 32'h00);
    chk("R5 stop pulse", {31'd0, eng_stop}, 32'h1);
    rd(2'd1, v); chk("R5 active until ack", v, 32'h81);
    wr(2'd0, 32'h09);
    chk("R11 no start while stop pending", {31'd0, eng_start}, 32'h0);
    rd(2'd0, v); chk("R11 command write ignored", v, 32'h00);
    pulse_ack();
    rd(2'd1, v); chk("R5 ack clears active", v, 32'h80);

    // R8 interrupt when idle
    pulse_irq();
    rd(2'd1, v); chk("R8 interrupt while idle", v, 32'h84);
    wr(2'd1, 32'h04);
    rd(2'd1, v); chk("R8 interrupt cleared by one", v, 32'h80);
    // R8 interrupt during transfer
    wr(2'd0, 32'h01);
    pulse_irq();
    rd(2'd1, v); chk("R8 interrupt held during transfer", v, 32'h81);
    pulse_done();
    rd(2'd1, v); chk("R8 interrupt after flush", v, 32'h84);
    wr(2'd0, 32'h00);
    wr(2'd1, 32'h04);

    // R7 error
    wr(2'd0, 32'h01);
    pulse_err();
    rd(2'd1, v); chk("R7 error set, active cleared", v, 32'h82);
    wr(2'd1, 32'h00);
    rd(2'd1, v); chk("R7 writing zero keeps error", v, 32'h82);
    wr(2'd1, 32'h02);
    rd(2'd1, v); chk("R7 error cleared by one", v, 32'h80);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 32'h02; eng_err = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; eng_err = 1'b0;
    rd(2'd1, v); chk("R7 set wins over clear", v, 32'h82);
    wr(2'd1, 32'h02);
    wr(2'd0, 32'h00);

    // R9 status storage
    wr(2'd1, 32'hFF);
    rd(2'd1, v); chk("R9 status after all-ones write", v, 32'hE0);
    wr(2'd1, 32'h20);
    rd(2'd1, v); chk("R9 drive flag 0 only", v, 32'hA0);
    wr(2'd1, 32'h00);
    rd(2'd1, v); chk("R9 flags cleared, simplex kept", v, 32'h80);

    // R12 unused selector
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); chk("R12 unused reads zero", v, 32'h0);
    rd(2'd2, v); chk("R12 pointer untouched", v, 32'h1234_5678);
    rd(2'd0, v); chk("R12 command untouched", v, 32'h0);
    rd(2'd1, v); chk("R12 status untouched", v, 32'h80);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule